// File: doc/BRIEF.md
# Bus Ownership and START Scheduling Controller

This controller sits between software-facing command logic and the bit engine of a two-wire serial bus master. It watches pulses from the line-condition detectors to decide whether the shared bus is occupied. Any START seen on the wire, including one from another master, marks the bus as taken. A STOP marks it free again.

A START command from software is never dropped because the bus happens to be occupied. It waits until the bus is free, and then the controller asks the bit engine to produce the START. When the bit engine reports that the START is on the wire, the controller moves on to the address byte. If the transmit buffer already holds that byte, the controller orders it loaded at once. If the buffer is empty, the controller holds the bus and waits for the byte to arrive. Once the address byte is out, the controller owns the bus until a STOP is seen.

Top module: `bus_start_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, `bus_busy`, `start_req`, `load_addr` and `hold_bus` are all 0. A reset applied mid-transaction clears all four on the next clock edge.
- R2: A `start_det` pulse without `stop_det` makes `bus_busy` 1 from the next cycle. It stays 1 until a STOP is detected.
- R3: A `stop_det` pulse makes `bus_busy` 0 from the next cycle. This holds even when `start_det` pulses in the same cycle, because STOP has priority.
- R4: A `start_cmd` while idle, with `bus_busy` at 0 and no `start_det` in that cycle, raises `start_req` in the next cycle.
- R5: A `start_cmd` while idle, when the bus is busy (or `start_det` pulses in the same cycle), is queued. `start_req` stays 0 while the bus is busy and rises one cycle after `bus_busy` falls.
- R6: `start_req` stays 1 until `start_done` is sampled high. It is 0 in the cycle after that.
- R7: If `txbuf_valid` is 1 when `start_done` is sampled, `load_addr` is 1 for exactly the next cycle and `hold_bus` stays 0.
- R8: If `txbuf_valid` is 0 when `start_done` is sampled, `hold_bus` is 1 from the next cycle. It stays 1 until `txbuf_valid` is sampled high. In the cycle after that, `hold_bus` is 0 and `load_addr` is 1 for one cycle.
- R9: `byte_done` during the address phase puts the controller in the owned state. A later `stop_det` returns it to idle, so that a new `start_cmd` on a free bus is served as in R4.
- R10: A `start_cmd` that arrives while a transaction is under way (any state other than idle) is ignored. No `start_req` follows it, even after the bus becomes free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_det | input | 1 | One-cycle pulse: START condition seen on the bus |
| stop_det | input | 1 | One-cycle pulse: STOP condition seen on the bus |
| start_cmd | input | 1 | One-cycle pulse: software requests a START |
| txbuf_valid | input | 1 | Transmit buffer holds a byte |
| start_done | input | 1 | Bit engine has placed the START on the wire |
| byte_done | input | 1 | Bit engine has finished shifting a byte |
| bus_busy | output | 1 | Bus occupied, registered |
| start_req | output | 1 | Request to the bit engine to generate a START |
| load_addr | output | 1 | One-cycle pulse: move buffered address byte into the shifter |
| hold_bus | output | 1 | Hold the bus while waiting for the address byte |

## Verification
Every output is a register fed by the current inputs and state, so every result is due exactly one clock edge after the stimulus that causes it. The one exception is a queued START. There the busy flag falls one edge after `stop_det`, and `start_req` rises one edge after that. The bench drives inputs on the falling edge and samples one time unit after the next rising edge. Each vector therefore compares the outputs produced by that vector's own inputs. The two-edge delay of a queued START shows up as one vector with `start_req` still 0, followed by one with it at 1.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  // Controller phases
  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_WAIT_FREE = 3'd1,
    PH_START     = 3'd2,
    PH_ADDR_WAIT = 3'd3,
    PH_ADDR_SEND = 3'd4,
    PH_OWNED     = 3'd5
  } phase_t;

  // Registered output bundle
  typedef struct packed {
    logic start_req;
    logic load_addr;
    logic hold_bus;
  } ctl_out_t;

endpackage

// File: rtl/bsc_bus_monitor.sv
module bsc_bus_monitor #(
  parameter bit STOP_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_det,
  input  logic stop_det,
  output logic busy
);

  logic busy_d;

  generate
    if (STOP_WINS) begin : g_stop_first
      always_comb begin
        busy_d = busy;
        if (stop_det)       busy_d = 1'b0;
        else if (start_det) busy_d = 1'b1;
      end
    end else begin : g_start_first
      always_comb begin
        busy_d = busy;
        if (start_det)     busy_d = 1'b1;
        else if (stop_det) busy_d = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) busy <= 1'b0;
    else     busy <= busy_d;
  end

  // R2
  busy_set_chk: assert property (@(posedge clk) disable iff (rst)
    (start_det && !stop_det) |=> busy);

  // R3
  busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_det && (STOP_WINS || !start_det)) |=> !busy);

endmodule

// File: rtl/bsc_sequencer.sv
module bsc_sequencer
  import bsc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   busy,
  input  logic   start_det,
  input  logic   stop_det,
  input  logic   start_cmd,
  input  logic   txbuf_valid,
  input  logic   start_done,
  input  logic   byte_done,
  output phase_t phase_q,
  output phase_t phase_d
);

  logic bus_free;

  // Free only if no START is arriving in this very cycle
  assign bus_free = !busy && !start_det;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_cmd) phase_d = bus_free ? PH_START : PH_WAIT_FREE;
      end
      PH_WAIT_FREE: begin
        if (bus_free) phase_d = PH_START;
      end
      PH_START: begin
        if (start_done) phase_d = txbuf_valid ? PH_ADDR_SEND : PH_ADDR_WAIT;
      end
      PH_ADDR_WAIT: begin
        if (txbuf_valid) phase_d = PH_ADDR_SEND;
      end
      PH_ADDR_SEND: begin
        if (byte_done) phase_d = PH_OWNED;
      end
      PH_OWNED: begin
        if (stop_det) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

  // R6
  start_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_START && !start_done) |=> phase_q == PH_START);

  // R9
  owned_release_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_OWNED && stop_det) |=> phase_q == PH_IDLE);

  // R10
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_OWNED && !stop_det) |=> phase_q == PH_OWNED);

endmodule

// File: rtl/bsc_out_regs.sv
module bsc_out_regs
  import bsc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  phase_t   phase_q,
  input  phase_t   phase_d,
  output ctl_out_t ctl_q
);

  ctl_out_t ctl_d;

  always_comb begin
    ctl_d.start_req = (phase_d == PH_START);
    ctl_d.hold_bus  = (phase_d == PH_ADDR_WAIT);
    ctl_d.load_addr = (phase_d == PH_ADDR_SEND) && (phase_q != PH_ADDR_SEND);
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_d;
  end

  // R7
  load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_q.load_addr |=> !ctl_q.load_addr);

endmodule

// File: rtl/bus_start_ctrl.sv
module bus_start_ctrl
  import bsc_pkg::*;
#(
  parameter bit STOP_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_det,
  input  logic stop_det,
  input  logic start_cmd,
  input  logic txbuf_valid,
  input  logic start_done,
  input  logic byte_done,
  output logic bus_busy,
  output logic start_req,
  output logic load_addr,
  output logic hold_bus
);

  phase_t   phase_q;
  phase_t   phase_d;
  ctl_out_t ctl_q;

  bsc_bus_monitor #(.STOP_WINS(STOP_WINS)) u_mon (
    .clk       (clk),
    .rst       (rst),
    .start_det (start_det),
    .stop_det  (stop_det),
    .busy      (bus_busy)
  );

  bsc_sequencer u_seq (
    .clk         (clk),
    .rst         (rst),
    .busy        (bus_busy),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .start_cmd   (start_cmd),
    .txbuf_valid (txbuf_valid),
    .start_done  (start_done),
    .byte_done   (byte_done),
    .phase_q     (phase_q),
    .phase_d     (phase_d)
  );

  bsc_out_regs u_out (
    .clk     (clk),
    .rst     (rst),
    .phase_q (phase_q),
    .phase_d (phase_d),
    .ctl_q   (ctl_q)
  );

  assign start_req = ctl_q.start_req;
  assign load_addr = ctl_q.load_addr;
  assign hold_bus  = ctl_q.hold_bus;

  // R4 R5: a START request only ever rises after a cycle with the bus free
  start_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(start_req) |-> !$past(bus_busy));

  // R8
  hold_until_data_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_bus && !txbuf_valid) |=> (hold_bus && !load_addr));

  // R8
  hold_release_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_bus && txbuf_valid) |=> (!hold_bus && load_addr));

endmodule

// File: tb/bus_start_ctrl_bench.sv
module bus_start_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 31;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_det = 1'b0, stop_det = 1'b0, start_cmd = 1'b0;
  logic txbuf_valid = 1'b0, start_done = 1'b0, byte_done = 1'b0;
  logic bus_busy, start_req, load_addr, hold_bus;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_start_ctrl u_bus_start_ctrl (
    .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
    .start_cmd(start_cmd), .txbuf_valid(txbuf_valid), .start_done(start_done),
    .byte_done(byte_done), .bus_busy(bus_busy), .start_req(start_req),
    .load_addr(load_addr), .hold_bus(hold_bus)
  );

  // Vector layout: {req[3:0], sd, pd, cmd, txv, sdone, bdone, busy, sreq, ld, hold}
  localparam logic [13:0] VEC [N_VEC] = '{
    {4'd1,  6'b000000, 4'b0000},  // R1 idle after reset
    {4'd4,  6'b001000, 4'b0100},  // R4 command on free bus
    {4'd6,  6'b000000, 4'b0100},  // R6 request held
    {4'd2,  6'b100000, 4'b1100},  // R2 own START seen
    {4'd7,  6'b000110, 4'b1010},  // R7 address ready -> load
    {4'd7,  6'b000100, 4'b1000},  // R7 load is one cycle
    {4'd9,  6'b000001, 4'b1000},  // R9 byte done -> owned
    {4'd10, 6'b001000, 4'b1000},  // R10 command while owned
    {4'd3,  6'b010000, 4'b0000},  // R3 STOP frees bus
    {4'd10, 6'b000000, 4'b0000},  // R10 nothing queued
    {4'd2,  6'b100000, 4'b1000},  // R2 foreign START
    {4'd5,  6'b001000, 4'b1000},  // R5 command queued
    {4'd5,  6'b000000, 4'b1000},  // R5 still waiting
    {4'd5,  6'b010000, 4'b0000},  // R5 busy drops, no request yet
    {4'd5,  6'b000000, 4'b0100},  // R5 request one cycle later
    {4'd2,  6'b100000, 4'b1100},  // R2 own START seen
    {4'd8,  6'b000010, 4'b1001},  // R8 no address -> hold
    {4'd8,  6'b000000, 4'b1001},  // R8 still holding
    {4'd8,  6'b000100, 4'b1010},  // R8 data arrives -> load
    {4'd8,  6'b000100, 4'b1000},  // R8 load ends
    {4'd9,  6'b000001, 4'b1000},  // R9 owned
    {4'd9,  6'b010000, 4'b0000},  // R9 STOP -> idle
    {4'd3,  6'b110000, 4'b0000},  // R3 START+STOP on free bus
    {4'd2,  6'b100000, 4'b1000},  // R2 busy
    {4'd3,  6'b110000, 4'b0000},  // R3 STOP wins
    {4'd5,  6'b101000, 4'b1000},  // R5 command with coincident START
    {4'd5,  6'b010000, 4'b0000},  // R5 STOP
    {4'd5,  6'b000000, 4'b0100},  // R5 issued
    {4'd7,  6'b000110, 4'b0010},  // R7 load
    {4'd9,  6'b000001, 4'b0000},  // R9 owned
    {4'd9,  6'b010000, 4'b0000}   // R9 idle again
  };

  task automatic check(input int req, input logic [3:0] exp);
    logic [3:0] act;
    act = {bus_busy, start_req, load_addr, hold_bus};
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL R%0d: outputs {busy,sreq,load,hold} actual %b expected %b at %0t",
               req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [5:0] in);
    @(negedge clk);
    {start_det, stop_det, start_cmd, txbuf_valid, start_done, byte_done} = in;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    check(1, 4'b0000);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check(1, 4'b0000);

    for (int i = 0; i < N_VEC; i++) begin
      drive(VEC[i][9:4]);
      check(int'(VEC[i][13:10]), VEC[i][3:0]);
    end

    // R6: request persists without start_done
    drive(6'b001000);
    check(4, 4'b0100);
    for (int k = 0; k < 6; k++) begin
      drive(6'b000000);
      check(6, 4'b0100);
    end
    drive(6'b000010);
    check(8, 4'b0001);

    // R1: reset mid-transaction clears everything
    @(negedge clk);
    rst = 1'b1;
    {start_det, stop_det, start_cmd, txbuf_valid, start_done, byte_done} = '0;
    @(posedge clk);
    #1;
    check(1, 4'b0000);
    @(negedge clk);
    rst = 1'b0;
    drive(6'b000100);
    check(1, 4'b0000);

    // R4 after reset: free bus served at once
    drive(6'b001000);
    check(4, 4'b0100);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule